// File: doc/BRIEF.md
# Single-Wire Bus Enumeration Sequencer

This block walks the identifier tree of every device attached to a single-wire bus. It does so by issuing a fixed sequence of primitive operations to a separate bus master. That master handles the bus timing and offers a search-accelerator mode. In that mode each byte exchanged carries four path bits out, and four chosen bits plus four discrepancy flags back. A search is triggered by a pulse on `start`, which carries the search command byte to send. The block then repeats passes until the identifier tree has been exhausted, or until it gives up.

Each pass runs these operations: a bus reset, the command byte, accelerator entry, sixteen path transfers, accelerator exit, and a closing reset. During the transfers the block gathers the 64-bit identifier picked by the bus and the mask of bit positions where devices disagreed. After a clean pass it presents the identifier on a one-cycle valid strobe. It then derives the next path from the disagreements it has not yet explored. Failures inside a pass lead to a retry. These are a timeout answer from the bus master, or an impossible answer on the last identifier bit. A pass budget bounds the whole search.

Top module: `enumSearch`

## Requirements
- R1: A pass issues, in this order, one request each: reset (op 0), write of the latched search command byte (op 1, reqData = command), accelerator on (op 2), sixteen transfers (op 4), accelerator off (op 3), reset (op 0). Transfers are only issued while the accelerator is on.
- R2: Transfer i carries path nibble i (path bits 4i to 4i+3). Path bit 4i+k is placed at reqData bit 2k+1, and the even bits are 0. The first pass of every search uses an all-zero path.
- R3: In transfer response i, bit 2k+1 is identifier bit 4i+k and bit 2k is the discrepancy flag of that position. After a clean pass the assembled identifier appears on idData with idValid high for exactly one cycle.
- R4: If the first reset of a pass answers with respPresence low, the search ends: done pulses with error low, no identifier is reported and no further request is issued.
- R5: A pass whose identifier bit 63 and discrepancy bit 63 are both 1 reports no identifier. The next pass reuses the same path.
- R6: A response with respTimeout high abandons the pass at once: the next request is a reset that begins a new pass with the same path.
- R7: The search allows at most 100 passes (parameter MAX_PASSES). Before starting pass 101 it ends with done and error high in the same cycle.
- R8: After a clean pass, discrepancy bits whose path bit is 1 are dropped. Let m be the highest remaining bit. The next path keeps the current path below m, sets bit m and clears everything above m.
- R9: When no discrepancy bit remains after that masking, the search ends with done high for one cycle and error low. Every device has then been reported exactly once, in ascending order of its bit-reversed identifier.
- R10: At most one request is outstanding: reqValid is high for one cycle per request and does not rise again before respValid.
- R11: After reset, reqValid, idValid, done and error are low and no request is made until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (sampled while idle) |
| searchCmd | input | 8 | Search command byte, latched at start |
| reqValid | output | 1 | One-cycle request strobe to the bus master |
| reqOp | output | 3 | Operation: 0 reset, 1 write byte, 2 accelerator on, 3 accelerator off, 4 transfer |
| reqData | output | 8 | Byte for write and transfer operations, 0 otherwise |
| respValid | input | 1 | One-cycle response strobe from the bus master |
| respData | input | 8 | Transfer response byte |
| respPresence | input | 1 | Presence seen on a reset response |
| respTimeout | input | 1 | Bus master gave up on the request |
| idValid | output | 1 | One-cycle strobe for a found identifier |
| idData | output | 64 | Found identifier |
| done | output | 1 | One-cycle end-of-search strobe |
| error | output | 1 | High with done when the pass budget ran out |

## Verification
A behavioural accelerator model filters a set of device identifiers bit by bit. The bench checks that device sets of one to three members are all reported in tree order. A three-device set checks the next-path rule directly through the transfer bytes of passes two and three. A design that cleared the lower path bits or skipped the masking would visit a wrong branch or loop on one device. Injected faults cover the recovery paths. A forced bit-63 error must not leak a bogus identifier. A timeout must restart with a reset and skip accelerator exit. A permanently failing bus must stop at exactly 100 passes, 200 resets, with error raised. A bus with no presence must end after a single request.

// File: rtl/enumSearchPkg.sv
package enumSearchPkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_ACC_ON  = 3'd2,
    OP_ACC_OFF = 3'd3,
    OP_XFER    = 3'd4
  } busOpE;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startSearch;
    logic beginPass;
    logic loadNibble;
    logic emitId;
    logic advancePath;
  } pathCtlS;

endpackage

// File: rtl/enumSearchPath.sv
module enumSearchPath
  import enumSearchPkg::*;
#(
  parameter int ID_W       = 64,
  parameter int MAX_PASSES = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  pathCtlS         ctl,
  input  logic [7:0]      searchCmd,
  input  busOpE           reqOp,
  input  logic [7:0]      respData,
  output logic [7:0]      reqData,
  output logic            busErr,
  output logic            noBranch,
  output logic            passLimit,
  output logic            lastNibble,
  output logic            idValid,
  output logic [ID_W-1:0] idData
);

  localparam int XFERS  = ID_W / 4;
  localparam int NIB_W  = $clog2(XFERS);
  localparam int IDX_W  = $clog2(ID_W);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);

  logic [ID_W-1:0]   path;
  logic [ID_W-1:0]   rAcc;
  logic [ID_W-1:0]   dAcc;
  logic [NIB_W-1:0]  nibIdx;
  logic [PASS_W-1:0] passCnt;
  logic [7:0]        cmdReg;

  logic [3:0]        curNib;
  logic [3:0]        rNib;
  logic [3:0]        dNib;
  logic [7:0]        xferByte;
  logic [ID_W-1:0]   openMask;
  logic [IDX_W-1:0]  topBit;
  logic [ID_W-1:0]   lowMask;
  logic [ID_W-1:0]   nextPath;

  function automatic logic [IDX_W-1:0] highBit(input logic [ID_W-1:0] v);
    highBit = '0;
    for (int b = 0; b < ID_W; b++) begin
      if (v[b]) highBit = IDX_W'(b);
    end
  endfunction

  assign curNib = path[{nibIdx, 2'b00} +: 4];

  // interleave: path bits on odd lanes out, chosen/discrepant pairs back
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign xferByte[2*k+1] = curNib[k];
    assign xferByte[2*k]   = 1'b0;
    assign rNib[k]         = respData[2*k+1];
    assign dNib[k]         = respData[2*k];
  end

  always_comb begin
    case (reqOp)
      OP_XFER:  reqData = xferByte;
      OP_WRITE: reqData = cmdReg;
      default:  reqData = 8'h00;
    endcase
  end

  assign openMask   = dAcc & ~path;
  assign topBit     = highBit(openMask);
  assign lowMask    = (ID_W'(1) << topBit) - ID_W'(1);
  assign nextPath   = (path & lowMask) | (ID_W'(1) << topBit);
  assign noBranch   = (openMask == '0);
  assign busErr     = rAcc[ID_W-1] & dAcc[ID_W-1];
  assign passLimit  = (passCnt == PASS_W'(MAX_PASSES));
  assign lastNibble = (nibIdx == NIB_W'(XFERS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      path    <= '0;
      rAcc    <= '0;
      dAcc    <= '0;
      nibIdx  <= '0;
      passCnt <= '0;
      cmdReg  <= '0;
      idValid <= 1'b0;
      idData  <= '0;
    end else begin
      idValid <= 1'b0;
      if (ctl.startSearch) begin
        path    <= '0;
        passCnt <= '0;
        cmdReg  <= searchCmd;
      end
      if (ctl.beginPass) begin
        passCnt <= passCnt + PASS_W'(1);
        rAcc    <= '0;
        dAcc    <= '0;
        nibIdx  <= '0;
      end
      if (ctl.loadNibble) begin
        rAcc[{nibIdx, 2'b00} +: 4] <= rNib;
        dAcc[{nibIdx, 2'b00} +: 4] <= dNib;
        nibIdx <= nibIdx + NIB_W'(1);
      end
      if (ctl.emitId) begin
        idValid <= 1'b1;
        idData  <= rAcc;
      end
      if (ctl.advancePath) path <= nextPath;
    end
  end

endmodule

// File: rtl/enumSearchCtrl.sv
module enumSearchCtrl
  import enumSearchPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    respValid,
  input  logic    respPresence,
  input  logic    respTimeout,
  input  logic    busErr,
  input  logic    noBranch,
  input  logic    passLimit,
  input  logic    lastNibble,
  output pathCtlS ctl,
  output logic    reqValid,
  output busOpE   reqOp,
  output logic    done,
  output logic    error
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_RST1, ST_CMD, ST_AON,
    ST_XFER, ST_AOFF, ST_RST2, ST_EVAL
  } stateE;

  stateE st, stNext;
  logic  waitResp, waitNext;
  logic  doneSet, errSet;

  always_comb begin
    case (st)
      ST_CMD:  reqOp = OP_WRITE;
      ST_AON:  reqOp = OP_ACC_ON;
      ST_XFER: reqOp = OP_XFER;
      ST_AOFF: reqOp = OP_ACC_OFF;
      default: reqOp = OP_RESET;
    endcase
  end

  always_comb begin
    stNext   = st;
    waitNext = waitResp;
    ctl      = '0;
    reqValid = 1'b0;
    doneSet  = 1'b0;
    errSet   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          ctl.startSearch = 1'b1;
          stNext = ST_START;
        end
      end
      ST_START: begin
        if (passLimit) begin
          doneSet = 1'b1;
          errSet  = 1'b1;
          stNext  = ST_IDLE;
        end else begin
          ctl.beginPass = 1'b1;
          stNext = ST_RST1;
        end
      end
      ST_EVAL: begin
        if (busErr) begin
          stNext = ST_START;
        end else begin
          ctl.emitId = 1'b1;
          if (noBranch) begin
            doneSet = 1'b1;
            stNext  = ST_IDLE;
          end else begin
            ctl.advancePath = 1'b1;
            stNext = ST_START;
          end
        end
      end
      default: begin
        if (!waitResp) begin
          reqValid = 1'b1;
          waitNext = 1'b1;
        end else if (respValid) begin
          waitNext = 1'b0;
          if (respTimeout) begin
            stNext = ST_START;
          end else begin
            case (st)
              ST_RST1: begin
                if (!respPresence) begin
                  doneSet = 1'b1;
                  stNext  = ST_IDLE;
                end else begin
                  stNext = ST_CMD;
                end
              end
              ST_CMD:  stNext = ST_AON;
              ST_AON:  stNext = ST_XFER;
              ST_XFER: begin
                ctl.loadNibble = 1'b1;
                if (lastNibble) stNext = ST_AOFF;
              end
              ST_AOFF: stNext = ST_RST2;
              default: stNext = ST_EVAL;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      waitResp <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      st       <= stNext;
      waitResp <= waitNext;
      done     <= doneSet;
      error    <= errSet;
    end
  end

endmodule

// File: rtl/enumSearch.sv
module enumSearch
  import enumSearchPkg::*;
#(
  parameter int ID_W       = 64,
  parameter int MAX_PASSES = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [7:0]      searchCmd,
  output logic            reqValid,
  output logic [2:0]      reqOp,
  output logic [7:0]      reqData,
  input  logic            respValid,
  input  logic [7:0]      respData,
  input  logic            respPresence,
  input  logic            respTimeout,
  output logic            idValid,
  output logic [ID_W-1:0] idData,
  output logic            done,
  output logic            error
);

  pathCtlS ctl;
  busOpE   opW;
  logic    busErr, noBranch, passLimit, lastNibble;

  assign reqOp = opW;

  enumSearchCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .respValid    (respValid),
    .respPresence (respPresence),
    .respTimeout  (respTimeout),
    .busErr       (busErr),
    .noBranch     (noBranch),
    .passLimit    (passLimit),
    .lastNibble   (lastNibble),
    .ctl          (ctl),
    .reqValid     (reqValid),
    .reqOp        (opW),
    .done         (done),
    .error        (error)
  );

  enumSearchPath #(.ID_W(ID_W), .MAX_PASSES(MAX_PASSES)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .searchCmd  (searchCmd),
    .reqOp      (opW),
    .respData   (respData),
    .reqData    (reqData),
    .busErr     (busErr),
    .noBranch   (noBranch),
    .passLimit  (passLimit),
    .lastNibble (lastNibble),
    .idValid    (idValid),
    .idData     (idData)
  );

endmodule

// File: rtl/enumSearchChecker.sv
module enumSearchChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       respValid,
  input logic       respTimeout,
  input logic       idValid,
  input logic       done,
  input logic       error
);

  logic pending, accOn, afterTo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      accOn   <= 1'b0;
      afterTo <= 1'b0;
    end else begin
      if (reqValid) pending <= 1'b1;
      else if (respValid) pending <= 1'b0;
      if (reqValid && reqOp == 3'd2) accOn <= 1'b1;
      else if (reqValid && (reqOp == 3'd3 || reqOp == 3'd0)) accOn <= 1'b0;
      if (respValid && respTimeout) afterTo <= 1'b1;
      else if (reqValid) afterTo <= 1'b0;
    end
  end

  assert_single_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !pending);

  assert_xfer_in_accel_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd4) |-> accOn);

  assert_retry_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && afterTo) |-> (reqOp == 3'd0));

  assert_error_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_id_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> !idValid);

endmodule

bind enumSearch enumSearchChecker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqOp       (reqOp),
  .respValid   (respValid),
  .respTimeout (respTimeout),
  .idValid     (idValid),
  .done        (done),
  .error       (error)
);

// File: tb/test_enumSearch.sv
module test_enumSearch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  searchCmd = 8'h00;
  logic        reqValid;
  logic [2:0]  reqOp;
  logic [7:0]  reqData;
  logic        respValid = 1'b0;
  logic [7:0]  respData = 8'h00;
  logic        respPresence = 1'b0;
  logic        respTimeout = 1'b0;
  logic        idValid;
  logic [63:0] idData;
  logic        done;
  logic        error;

  always #5 clk = ~clk;

  enumSearch i_enumSearch (
    .clk(clk), .rstN(rstN), .start(start), .searchCmd(searchCmd),
    .reqValid(reqValid), .reqOp(reqOp), .reqData(reqData),
    .respValid(respValid), .respData(respData),
    .respPresence(respPresence), .respTimeout(respTimeout),
    .idValid(idValid), .idData(idData), .done(done), .error(error)
  );

  typedef struct packed {
    logic [2:0]  num;
    logic [7:0]  cmd;
    logic [63:0] idA;
    logic [63:0] idB;
    logic [63:0] idC;
  } vecT;

  localparam vecT VECS [4] = '{
    '{3'd1, 8'hF0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0},
    '{3'd2, 8'hEC, 64'h3C00_0000_0000_0031, 64'h3C00_0000_0000_0011, 64'h0},
    '{3'd3, 8'hF0, 64'hA500_0000_0000_0024, 64'hA500_0000_0000_0000, 64'hA500_0000_0000_0004},
    '{3'd3, 8'hEC, 64'hFFFF_0000_1111_2222, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001}
  };

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [63:0] devs [4];
  int          nDevs = 0;
  logic [3:0]  alive = '0;
  int          xferIdx = 0, accOnCnt = 0, accOffCnt = 0, resetCnt = 0, reqCnt = 0;
  int          busErrPasses = 0, toPass = 0, toXfer = 0;
  logic [7:0]  xferLog [4][16];
  logic [2:0]  opLog [64];
  logic [7:0]  dataLog [64];

  logic [63:0] foundLog [8];
  int          foundCnt = 0;
  bit          doneSeen = 0, errSeen = 0;
  logic [63:0] expIds [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] x);
    for (int i = 0; i < 64; i++) rev64[i] = x[63-i];
  endfunction

  task automatic clearLogs();
    xferIdx = 0; accOnCnt = 0; accOffCnt = 0; resetCnt = 0; reqCnt = 0;
    foundCnt = 0; doneSeen = 0; errSeen = 0;
    for (int p = 0; p < 4; p++)
      for (int x = 0; x < 16; x++) xferLog[p][x] = 8'hEE;
  endtask

  task automatic runSearch(input logic [7:0] cmd);
    clearLogs();
    @(negedge clk);
    searchCmd = cmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 60000 && !doneSeen; c++) @(negedge clk);
    chk(doneSeen, "R9", "search did not finish", 64'(doneSeen), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  // accelerator model and request logger
  initial begin : responder
    logic [2:0] op;
    logic [7:0] dat, rd;
    logic       pres, tmo, has0, has1, chosen, disc;
    int         b;
    forever begin
      @(negedge clk);
      respValid = 1'b0;
      respTimeout = 1'b0;
      if (rstN && reqValid) begin
        op = reqOp; dat = reqData;
        if (reqCnt < 64) begin opLog[reqCnt] = op; dataLog[reqCnt] = dat; end
        reqCnt++;
        rd = 8'h00; pres = 1'b0; tmo = 1'b0;
        case (op)
          3'd0: begin
            resetCnt++;
            for (int j = 0; j < 4; j++) alive[j] = (j < nDevs);
            pres = (nDevs > 0);
          end
          3'd2: begin accOnCnt++; xferIdx = 0; end
          3'd3: accOffCnt++;
          3'd4: begin
            if (accOnCnt >= 1 && accOnCnt <= 4 && xferIdx < 16)
              xferLog[accOnCnt-1][xferIdx] = dat;
            for (int k = 0; k < 4; k++) begin
              b = xferIdx * 4 + k;
              has0 = 1'b0; has1 = 1'b0;
              for (int j = 0; j < nDevs; j++)
                if (alive[j]) begin
                  if (devs[j][b]) has1 = 1'b1; else has0 = 1'b1;
                end
              if (has0 && has1) begin chosen = dat[2*k+1]; disc = 1'b1; end
              else if (has1)    begin chosen = 1'b1; disc = 1'b0; end
              else if (has0)    begin chosen = 1'b0; disc = 1'b0; end
              else              begin chosen = 1'b1; disc = 1'b1; end
              for (int j = 0; j < nDevs; j++)
                if (devs[j][b] != chosen) alive[j] = 1'b0;
              rd[2*k+1] = chosen;
              rd[2*k]   = disc;
            end
            if (xferIdx == 15 && accOnCnt <= busErrPasses) rd[7:6] = 2'b11;
            if (accOnCnt == toPass && xferIdx == toXfer) tmo = 1'b1;
            xferIdx++;
          end
          default: ;
        endcase
        @(negedge clk);
        respValid = 1'b1; respData = rd; respPresence = pres; respTimeout = tmo;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (idValid) begin
        if (foundCnt < 8) foundLog[foundCnt] = idData;
        foundCnt++;
      end
      if (done) begin doneSeen = 1; errSeen = error; end
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit allZero;
    bit used [4];
    int best;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!reqValid && !idValid && !done && !error, "R11", "outputs after reset",
        {60'd0, reqValid, idValid, done, error}, 64'd0);
    repeat (5) @(negedge clk);
    chk(reqCnt == 0, "R11", "requests before start", 64'(reqCnt), 64'd0);

    // table of device sets
    for (int v = 0; v < 4; v++) begin
      nDevs = VECS[v].num;
      devs[0] = VECS[v].idA; devs[1] = VECS[v].idB; devs[2] = VECS[v].idC; devs[3] = '0;
      busErrPasses = 0; toPass = 0;
      for (int j = 0; j < 4; j++) used[j] = 0;
      for (int p = 0; p < nDevs; p++) begin
        best = -1;
        for (int j = 0; j < nDevs; j++)
          if (!used[j] && (best < 0 || rev64(devs[j]) < rev64(devs[best]))) best = j;
        used[best] = 1;
        expIds[p] = devs[best];
      end
      runSearch(VECS[v].cmd);
      chk(!errSeen, "R9", "error on clean search", 64'(errSeen), 64'd0);
      chk(foundCnt == nDevs, "R9", "identifier count", 64'(foundCnt), 64'(nDevs));
      for (int p = 0; p < nDevs && p < foundCnt; p++)
        chk(foundLog[p] == expIds[p], "R3", "identifier in tree order", foundLog[p], expIds[p]);
      chk(resetCnt == 2 * nDevs, "R1", "two resets per pass", 64'(resetCnt), 64'(2 * nDevs));
      allZero = 1;
      for (int x = 0; x < 16; x++) if (xferLog[0][x] != 8'h00) allZero = 0;
      chk(allZero, "R2", "first pass path zero", 64'(xferLog[0][0]), 64'd0);
      if (v == 0) begin
        chk(reqCnt == 21, "R10", "one request per operation", 64'(reqCnt), 64'd21);
        chk(opLog[0] == 3'd0 && opLog[1] == 3'd1 && opLog[2] == 3'd2,
            "R1", "pass head ops", {opLog[0], opLog[1], opLog[2]}, {3'd0, 3'd1, 3'd2});
        chk(dataLog[1] == VECS[v].cmd, "R1", "command byte", 64'(dataLog[1]), 64'(VECS[v].cmd));
        allZero = 1;
        for (int x = 3; x < 19; x++) if (opLog[x] != 3'd4) allZero = 0;
        chk(allZero, "R1", "sixteen transfers", 64'(opLog[3]), 64'd4);
        chk(opLog[19] == 3'd3 && opLog[20] == 3'd0, "R1", "pass tail ops",
            {opLog[19], opLog[20]}, {3'd3, 3'd0});
      end
      if (v == 2) begin
        // pass 2 path = bit 2 -> transfer 0 byte bit 5
        chk(xferLog[1][0] == 8'h20 && xferLog[1][1] == 8'h00, "R8", "second pass path",
            {xferLog[1][0], xferLog[1][1]}, {8'h20, 8'h00});
        // pass 3 path = bits 2 and 5 -> 0x20, 0x08 (lower bit kept)
        chk(xferLog[2][0] == 8'h20 && xferLog[2][1] == 8'h08, "R8", "third pass keeps lower bits",
            {xferLog[2][0], xferLog[2][1]}, {8'h20, 8'h08});
        allZero = 1;
        for (int x = 2; x < 16; x++) if (xferLog[2][x] != 8'h00) allZero = 0;
        chk(allZero, "R2", "upper path nibbles clear", 64'(xferLog[2][2]), 64'd0);
      end
    end

    // R4 no presence
    nDevs = 0;
    runSearch(8'hF0);
    chk(!errSeen && foundCnt == 0, "R4", "empty bus result", {errSeen, 32'(foundCnt)}, 64'd0);
    chk(reqCnt == 1, "R4", "single request on empty bus", 64'(reqCnt), 64'd1);

    // R5 bus error on first pass
    nDevs = 1; devs[0] = 64'h5A5A_0000_1234_0001;
    busErrPasses = 1; toPass = 0;
    runSearch(8'hF0);
    chk(foundCnt == 1 && foundLog[0] == devs[0], "R5", "only retried pass reports",
        foundLog[0], devs[0]);
    chk(resetCnt == 4, "R5", "resets with one retry", 64'(resetCnt), 64'd4);
    allZero = 1;
    for (int x = 0; x < 16; x++) if (xferLog[1][x] != 8'h00) allZero = 0;
    chk(allZero, "R5", "retry keeps path", 64'(xferLog[1][0]), 64'd0);

    // R6 timeout on transfer 7 of pass 1
    busErrPasses = 0; toPass = 1; toXfer = 7;
    runSearch(8'hEC);
    chk(foundCnt == 1 && foundLog[0] == devs[0], "R6", "identifier after timeout retry",
        foundLog[0], devs[0]);
    chk(resetCnt == 3 && accOffCnt == 1, "R6", "abandoned pass skips exit",
        {32'(resetCnt), 32'(accOffCnt)}, {32'd3, 32'd1});
    chk(opLog[11] == 3'd0, "R6", "request after timeout", 64'(opLog[11]), 64'd0);
    chk(!errSeen, "R6", "no error after recovery", 64'(errSeen), 64'd0);

    // R7 pass budget
    toPass = 0; busErrPasses = 100000;
    runSearch(8'hF0);
    chk(errSeen, "R7", "error after pass budget", 64'(errSeen), 64'd1);
    chk(foundCnt == 0, "R7", "no identifier reported", 64'(foundCnt), 64'd0);
    chk(resetCnt == 200, "R7", "exactly 100 passes", 64'(resetCnt), 64'd200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule